// File: doc/BRIEF.md
# Register-Mapped Debug Probe Multiplexer

This peripheral brings internal observation signals out to eight debug pins. Every pin has its own 4-bit selector that picks one of sixteen candidate signals. The candidates for all pins arrive packed into one 128-bit input. On every pin, the highest selector code does not pick an observed signal. It routes a software-owned general-purpose output bit to the pin instead. Software sets and clears these bits one at a time through dedicated registers.

A single global enable gates all eight pins. The pin outputs are registered, so a change of selector never produces a glitch on a pad. Software reaches the block through a plain 32-bit register port with a write strobe, an address, write data and registered read data. A read-only window shows the live pin values. Fixed version and identification words let software detect the block.

Top module: `dbg_probe_mux`

## Requirements
- R1: Synchronous active-high reset clears the enable, every selector and every general-purpose output bit. It drives all pins and `bus_rdata` to 0.
- R2: While enabled, pin n shows `probe_in[16*n + code]` for selector codes 0 to 14. The value appears on the clock edge after the selector and input are stable, because each pin has one register stage.
- R3: Selector code 15 on pin n drives general-purpose output bit n onto pin n, and `probe_in` has no effect on that pin.
- R4: Bit 0 of the control register (offset 0x000) is the global enable. While it is 0, every pin and the pin-value readback (offset 0x010) are 0.
- R5: Writing to the set register (offset 0x014) sets each general-purpose output bit whose write-data bit (bits 7:0) is 1. Bits written as 0 are unchanged. Reading offset 0x014 returns the current bits in 7:0.
- R6: Writing to the clear register (offset 0x018) clears each bit whose write-data bit is 1, leaves the others unchanged, and reads back 0.
- R7: Offset 0x01C reads the general-purpose output bits in 7:0. Writes to 0x01C change nothing.
- R8: The selector register (offset 0x004) is read and written in full, with pin n's selector in bits [4n+3:4n].
- R9: Offset 0x3F4 reads 0x00000010 (major revision 1 in bits 7:4, minor revision 0 in bits 3:0). Offset 0x3F8 reads 0x0050524D and offset 0x3FC reads 0xA3C5DD01.
- R10: Reads from any other offset return 0. Writes to any other offset leave every register and pin unchanged.
- R11: `bus_rdata` is registered. It shows the register addressed in one cycle on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| probe_in | input | 128 | Candidate signals, 16 per pin, pin n in bits [16n+15:16n] |
| probe_out | output | 8 | Registered debug pin values |

## Verification
Properties checked on every cycle:
- The post-reset state.
- The forcing of pins to zero one cycle after the enable is off.
- The effect of each set or clear write on the addressed bits.
- That the output bits hold through any other bus activity.
- The read data returned for the version and unmapped offsets.

The scenarios cover the rest:
- The per-pin routing of each selector code, including code 15 against the observed inputs.
- The live pin readback.
- Writes to read-only or unmapped offsets having no effect.

These scenarios use a model of the register state that the scenarios update themselves.

// File: rtl/dbg_probe_pkg.sv
package dbg_probe_pkg;
  localparam int unsigned OFF_CTRL = 32'h000;
  localparam int unsigned OFF_SEL  = 32'h004;
  localparam int unsigned OFF_PINS = 32'h010;
  localparam int unsigned OFF_SET  = 32'h014;
  localparam int unsigned OFF_CLR  = 32'h018;
  localparam int unsigned OFF_GVAL = 32'h01C;
  localparam int unsigned OFF_VER  = 32'h3F4;
  localparam int unsigned OFF_ID0  = 32'h3F8;
  localparam int unsigned OFF_ID1  = 32'h3FC;

  typedef enum logic [3:0] {
    RS_CTRL, RS_SEL, RS_PINS, RS_SET, RS_CLR, RS_GVAL, RS_VER, RS_ID0, RS_ID1, RS_NONE
  } reg_sel_e;
endpackage

// File: rtl/dbg_probe_lane.sv
module dbg_probe_lane #(
  parameter int SEL_W = 4,
  localparam int FUNCS = 1 << SEL_W,
  localparam logic [SEL_W-1:0] GPO_CODE = SEL_W'(FUNCS - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [FUNCS-1:0] cand,
  input  logic             gpo_bit,
  output logic             pin_q
);
  logic pick;

  always_comb begin
    if (sel == GPO_CODE) pick = gpo_bit;
    else                 pick = cand[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= en & pick;
  end
endmodule

// File: rtl/dbg_probe_regs.sv
module dbg_probe_regs
  import dbg_probe_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 8,
  parameter int SEL_W    = 4,
  parameter logic [3:0] VER_MAJOR = 4'd1,
  parameter logic [3:0] VER_MINOR = 4'd0,
  parameter logic [DATA_W-1:0] ID_WORD0 = 32'h0050_524D,
  parameter logic [DATA_W-1:0] ID_WORD1 = 32'hA3C5_DD01,
  localparam int SELS_W = NUM_PINS * SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pins,
  output logic                en_q,
  output logic [SELS_W-1:0]   sel_q,
  output logic [NUM_PINS-1:0] gpo_q
);
  reg_sel_e            rs;
  logic [DATA_W-1:0]   rd_mux;
  logic [NUM_PINS-1:0] wbits;

  assign wbits = bus_wdata[NUM_PINS-1:0];

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_CTRL): rs = RS_CTRL;
      ADDR_W'(OFF_SEL):  rs = RS_SEL;
      ADDR_W'(OFF_PINS): rs = RS_PINS;
      ADDR_W'(OFF_SET):  rs = RS_SET;
      ADDR_W'(OFF_CLR):  rs = RS_CLR;
      ADDR_W'(OFF_GVAL): rs = RS_GVAL;
      ADDR_W'(OFF_VER):  rs = RS_VER;
      ADDR_W'(OFF_ID0):  rs = RS_ID0;
      ADDR_W'(OFF_ID1):  rs = RS_ID1;
      default:           rs = RS_NONE;
    endcase
  end

  always_comb begin
    rd_mux = '0;
    case (rs)
      RS_CTRL: rd_mux[0] = en_q;
      RS_SEL:  rd_mux[SELS_W-1:0] = sel_q;
      RS_PINS: rd_mux[NUM_PINS-1:0] = pins;
      RS_SET:  rd_mux[NUM_PINS-1:0] = gpo_q;
      RS_GVAL: rd_mux[NUM_PINS-1:0] = gpo_q;
      RS_VER:  rd_mux[7:0] = {VER_MAJOR, VER_MINOR};
      RS_ID0:  rd_mux = ID_WORD0;
      RS_ID1:  rd_mux = ID_WORD1;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      sel_q     <= '0;
      gpo_q     <= '0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_mux;
      if (bus_we) begin
        case (rs)
          RS_CTRL: en_q  <= bus_wdata[0];
          RS_SEL:  sel_q <= bus_wdata[SELS_W-1:0];
          RS_SET:  gpo_q <= gpo_q | wbits;
          RS_CLR:  gpo_q <= gpo_q & ~wbits;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg_probe_mux.sv
module dbg_probe_mux #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 8,
  parameter int SEL_W    = 4,
  localparam int FUNCS   = 1 << SEL_W,
  localparam int IN_W    = NUM_PINS * FUNCS,
  localparam int SELS_W  = NUM_PINS * SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [IN_W-1:0]     probe_in,
  output logic [NUM_PINS-1:0] probe_out
);
  logic                en_q;
  logic [SELS_W-1:0]   sel_q;
  logic [NUM_PINS-1:0] gpo_q;

  dbg_probe_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PINS(NUM_PINS), .SEL_W(SEL_W)
  ) regs_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins(probe_out),
    .en_q(en_q), .sel_q(sel_q), .gpo_q(gpo_q)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
    dbg_probe_lane #(.SEL_W(SEL_W)) lane_i (
      .clk(clk), .rst(rst), .en(en_q),
      .sel(sel_q[p*SEL_W +: SEL_W]),
      .cand(probe_in[p*FUNCS +: FUNCS]),
      .gpo_bit(gpo_q[p]),
      .pin_q(probe_out[p])
    );
  end
endmodule

// File: rtl/dbg_probe_mux_chk.sv
module dbg_probe_mux_chk
  import dbg_probe_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] probe_out,
  input logic                en_q,
  input logic [NUM_PINS-1:0] gpo_q
);
  logic is_set, is_clr, mapped;
  assign is_set = bus_addr == ADDR_W'(OFF_SET);
  assign is_clr = bus_addr == ADDR_W'(OFF_CLR);
  assign mapped = bus_addr == ADDR_W'(OFF_CTRL) || bus_addr == ADDR_W'(OFF_SEL)
               || bus_addr == ADDR_W'(OFF_PINS) || is_set || is_clr
               || bus_addr == ADDR_W'(OFF_GVAL) || bus_addr == ADDR_W'(OFF_VER)
               || bus_addr == ADDR_W'(OFF_ID0) || bus_addr == ADDR_W'(OFF_ID1);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (probe_out == '0 && !en_q && gpo_q == '0 && bus_rdata == '0));

  // R4
  disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> probe_out == '0);

  // R5
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && is_set) |=> ((gpo_q & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

  // R6
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && is_clr) |=> ((gpo_q & $past(bus_wdata[NUM_PINS-1:0])) == '0));

  // R7
  gpo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && (is_set || is_clr)) |=> $stable(gpo_q));

  // R9
  version_word_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(OFF_VER)) |=> bus_rdata == 32'h0000_0010);

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> bus_rdata == '0);
endmodule

bind dbg_probe_mux dbg_probe_mux_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PINS(NUM_PINS)
) chk_i (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .probe_out(probe_out),
  .en_q(en_q), .gpo_q(gpo_q)
);

// File: tb/dbg_probe_mux_tb_top.sv
module dbg_probe_mux_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_we = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] probe_in = '0;
  logic [7:0]   probe_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic        m_en;
  logic [31:0] m_sel;
  logic [7:0]  m_gpo;

  always #5 clk = ~clk;

  dbg_probe_mux dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .probe_in(probe_in), .probe_out(probe_out)
  );

  function automatic logic [7:0] exp_pins(input logic en, input logic [31:0] s,
                                          input logic [7:0] g, input logic [127:0] p);
    logic [7:0] r;
    r = '0;
    for (int n = 0; n < 8; n++) begin
      int c;
      c = int'(s[4*n +: 4]);
      if (en) r[n] = (c == 15) ? g[n] : p[16*n + c];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      12'h000: m_en  = d[0];
      12'h004: m_sel = d;
      12'h014: m_gpo = m_gpo | d[7:0];
      12'h018: m_gpo = m_gpo & ~d[7:0];
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic drive_and_check(input string req, input logic [127:0] v);
    logic [31:0] r;
    probe_in = v;
    @(negedge clk);
    chk(req, {24'h0, probe_out}, {24'h0, exp_pins(m_en, m_sel, m_gpo, probe_in)});
    bus_rd(12'h010, r);
    chk(req, r, {24'h0, exp_pins(m_en, m_sel, m_gpo, probe_in)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4711));
    m_en = 1'b0; m_sel = '0; m_gpo = '0;
    probe_in = {128{1'b1}};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", {24'h0, probe_out}, 32'h0);
    chk("R1", bus_rdata, 32'h0);
    bus_rd(12'h000, r); chk("R1", r, 32'h0);
    bus_rd(12'h004, r); chk("R1", r, 32'h0);
    bus_rd(12'h01C, r); chk("R1", r, 32'h0);

    // R9 and R11: fixed words, one cycle after the address
    bus_rd(12'h3F4, r); chk("R9", r, 32'h0000_0010);
    bus_rd(12'h3F8, r); chk("R9", r, 32'h0050_524D);
    bus_rd(12'h3FC, r); chk("R11", r, 32'hA3C5_DD01);

    // R10: unmapped reads and writes
    bus_rd(12'h008, r); chk("R10", r, 32'h0);
    bus_rd(12'h020, r); chk("R10", r, 32'h0);
    bus_rd(12'h3F0, r); chk("R10", r, 32'h0);
    bus_wr(12'h00C, 32'hFFFF_FFFF);
    bus_wr(12'h3F4, 32'hFFFF_FFFF);
    bus_rd(12'h000, r); chk("R10", r, 32'h0);
    bus_rd(12'h004, r); chk("R10", r, 32'h0);
    bus_rd(12'h014, r); chk("R10", r, 32'h0);
    chk("R10", {24'h0, probe_out}, 32'h0);

    // R4: disabled port keeps pins at zero
    bus_wr(12'h004, 32'h0);
    drive_and_check("R4", {128{1'b1}});

    // R8: selector layout readback
    bus_wr(12'h004, 32'h7654_3210);
    bus_rd(12'h004, r); chk("R8", r, 32'h7654_3210);

    // R2: enable and route per-pin codes
    bus_wr(12'h000, 32'h1);
    bus_rd(12'h000, r); chk("R4", r, 32'h1);
    drive_and_check("R2", 128'h0080_0040_0020_0010_0008_0004_0002_0001);
    drive_and_check("R2", 128'hFF7F_FFBF_FFDF_FFEF_FFF7_FFFB_FFFD_FFFE);
    bus_wr(12'h004, 32'hEEEE_EEEE);
    drive_and_check("R2", 128'h4000_4000_4000_4000_0000_0000_0000_0000);

    // R5, R6, R7: output bits, zero bits, read-only value register
    bus_wr(12'h014, 32'h0000_00A5);
    bus_rd(12'h014, r); chk("R5", r, 32'hA5);
    bus_wr(12'h014, 32'h0000_0000);
    bus_rd(12'h01C, r); chk("R5", r, 32'hA5);
    bus_wr(12'h018, 32'h0000_0021);
    bus_rd(12'h01C, r); chk("R6", r, 32'h84);
    bus_wr(12'h018, 32'h0000_0000);
    bus_rd(12'h018, r); chk("R6", r, 32'h0);
    bus_rd(12'h01C, r); chk("R6", r, 32'h84);
    bus_wr(12'h01C, 32'hFFFF_FFFF);
    bus_rd(12'h01C, r); chk("R7", r, 32'h84);

    // R3: code 15 ignores the observed inputs
    bus_wr(12'h004, 32'hFFFF_FFFF);
    drive_and_check("R3", {128{1'b1}});
    drive_and_check("R3", 128'h0);

    // R4: disable again with routed ones
    bus_wr(12'h014, 32'hFF);
    bus_wr(12'h000, 32'h0);
    drive_and_check("R4", {128{1'b1}});

    // R2 R3 R5 R6: constrained random
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0:       bus_wr(12'h000, {31'h0, ($urandom_range(0, 3) != 0)});
        1, 2, 3: bus_wr(12'h004, $urandom);
        4:       bus_wr(12'h014, {24'h0, 8'($urandom)});
        5:       bus_wr(12'h018, {24'h0, 8'($urandom)});
        default: ;
      endcase
      drive_and_check("R2", {$urandom, $urandom, $urandom, $urandom});
      if (op == 4 || op == 5) begin
        bus_rd(12'h01C, r); chk("R5", r, {24'h0, m_gpo});
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule